// File: doc/BRIEF.md
# DRAM Refresh Request Scheduler

This block decides when a DRAM refresh cycle runs. A free-running divider counts system clock cycles and raises a refresh request once per programmed interval of 16 × (N + 1) clocks, where N is an 8-bit rate value. A request that falls due while a memory burst is in flight is held pending. It starts on the first cycle with no burst active. The divider keeps counting while the request waits, so deferral never stretches the long-term refresh rate.

Once started, a refresh occupies a fixed four-cycle window, flagged by a busy output. A DRAM access requested during that window is parked and granted as soon as the window closes. A request aimed at any other target is granted on the next cycle whatever the refresh state. When a due refresh and a DRAM request arrive in the same idle cycle, the refresh takes the slot and the access follows it.

Top module: `rfs_scheduler`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `refresh_stb`, `refresh_busy` and `mem_grant` are all 0.
- R2: With no burst activity, `refresh_stb` pulses high for one cycle every 16 × (N + 1) clocks. The first pulse is seen 16 × (N + 1) clock edges after reset is released. This holds for N = 0 and for N = 255.
- R3: With `rate_val` = 24 the interval between refresh strobes is exactly 400 clocks.
- R4: A refresh that falls due while `burst_active` is 1 does not start. Its strobe appears in the cycle after the first cycle in which `burst_active` is sampled 0, and never later than 6 cycles after the due time when bursts last at most 6 cycles.
- R5: Deferring a refresh does not restart the period. The following strobe still comes at the next multiple of 16 × (N + 1) clocks counted from reset.
- R6: `refresh_busy` is 1 for exactly 4 consecutive cycles starting with the cycle of `refresh_stb`. `refresh_stb` is high only in the first of them.
- R7: A DRAM request (`mem_req` = 1 with `req_dram` = 1) made while no refresh is running or starting is granted with a one-cycle `mem_grant` pulse in the next cycle. One made during a refresh is held, and its grant appears in the first cycle in which `refresh_busy` is 0 again.
- R8: If a refresh can start in the same cycle that a DRAM request arrives, the refresh starts first. The request is granted 4 cycles after the strobe.
- R9: A request with `req_dram` = 0 is granted in the next cycle even while `refresh_busy` is 1.
- R10: A refresh never starts in a cycle in which `burst_active` is sampled 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_val | input | 8 | Programmed rate N; period is 16 × (N + 1) clocks |
| burst_active | input | 1 | A memory burst is in progress |
| mem_req | input | 1 | One-cycle access request strobe |
| req_dram | input | 1 | Qualifies `mem_req`: 1 = DRAM target, 0 = other target |
| refresh_stb | output | 1 | One-cycle pulse at the start of a refresh cycle |
| refresh_busy | output | 1 | Refresh cycle in progress |
| mem_grant | output | 1 | One-cycle grant for an access request |

## Verification
Two collisions can fall in the same cycle. The first is a refresh falling due on a cycle where a burst is still active; the bench provokes it by raising `burst_active` across the due time. The strobe is then expected one cycle after the burst drops, and the next strobe on the original grid. The second is a DRAM request arriving on the very cycle a refresh starts; the bench drives it on the due cycle with the bus idle and expects the strobe first and the grant four cycles later. A behavioural model runs alongside, and every output is compared against it on every clock.

// File: rtl/rfs_pkg.sv
package rfs_pkg;

    // Fixed divide-by-16 stage in front of the programmable rate counter
    localparam int unsigned PRESCALE_W = 4;

    // Status handed from the refresh controller to the access gate
    typedef struct packed {
        logic start;  // refresh is being launched this cycle
        logic free;   // next cycle has no refresh running
    } ref_status_t;

endpackage

// File: rtl/rfs_period_timer.sv
module rfs_period_timer #(
    parameter int unsigned RATE_W = 8,
    parameter int unsigned PRE_W  = rfs_pkg::PRESCALE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    output logic              due_o
);

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [RATE_W-1:0] rate_cnt;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic       pre_wrap;
    logic       rate_hit;

    always_comb begin
        st_d     = st_q;
        pre_wrap = (st_q.pre == {PRE_W{1'b1}});
        rate_hit = (st_q.rate_cnt >= rate_i);
        due_o    = pre_wrap && rate_hit;

        st_d.pre = st_q.pre + 1'b1;
        if (pre_wrap) begin
            if (rate_hit) begin
                st_d.rate_cnt = '0;
            end else begin
                st_d.rate_cnt = st_q.rate_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/rfs_refresh_ctl.sv
module rfs_refresh_ctl #(
    parameter int unsigned REF_CYCLES = 4,
    localparam int unsigned CNT_W     = $clog2(REF_CYCLES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                due_i,
    input  logic                burst_i,
    output logic                strobe_o,
    output logic                busy_o,
    output logic                pend_o,
    output rfs_pkg::ref_status_t status_o
);

    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REF_CYCLES);

    typedef struct packed {
        logic             pend;
        logic [CNT_W-1:0] cnt;
        logic             strobe;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       cand;
    logic       launch;
    logic       idle;

    always_comb begin
        st_d   = st_q;
        idle   = (st_q.cnt == '0);
        cand   = st_q.pend || due_i;
        launch = cand && !burst_i && idle;

        st_d.pend   = cand && !launch;
        st_d.strobe = launch;
        if (launch) begin
            st_d.cnt = CNT_LOAD;
        end else if (!idle) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end

        status_o.start = launch;
        status_o.free  = (st_q.cnt <= CNT_W'(1)) && !launch;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = st_q.strobe;
    assign busy_o   = (st_q.cnt != '0);
    assign pend_o   = st_q.pend;

endmodule

// File: rtl/rfs_access_gate.sv
module rfs_access_gate (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_i,
    input  logic                 dram_i,
    input  rfs_pkg::ref_status_t status_i,
    output logic                 grant_o,
    output logic                 hold_o
);

    typedef struct packed {
        logic hold;
        logic grant;
    } gate_state_t;

    gate_state_t st_d, st_q;
    logic        want;
    logic        dram_go;

    always_comb begin
        st_d    = st_q;
        want    = st_q.hold || (req_i && dram_i);
        dram_go = want && status_i.free;

        st_d.hold  = want && !status_i.free;
        st_d.grant = dram_go || (req_i && !dram_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o = st_q.grant;
    assign hold_o  = st_q.hold;

endmodule

// File: rtl/rfs_scheduler.sv
module rfs_scheduler #(
    parameter int unsigned RATE_W     = 8,
    parameter int unsigned REF_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_val,
    input  logic              burst_active,
    input  logic              mem_req,
    input  logic              req_dram,
    output logic              refresh_stb,
    output logic              refresh_busy,
    output logic              mem_grant
);

    logic                 due_w;
    logic                 pend_w;
    logic                 hold_w;
    rfs_pkg::ref_status_t status_w;

    rfs_period_timer #(
        .RATE_W (RATE_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .rate_i (rate_val),
        .due_o  (due_w)
    );

    rfs_refresh_ctl #(
        .REF_CYCLES (REF_CYCLES)
    ) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .due_i    (due_w),
        .burst_i  (burst_active),
        .strobe_o (refresh_stb),
        .busy_o   (refresh_busy),
        .pend_o   (pend_w),
        .status_o (status_w)
    );

    rfs_access_gate u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (mem_req),
        .dram_i   (req_dram),
        .status_i (status_w),
        .grant_o  (mem_grant),
        .hold_o   (hold_w)
    );

endmodule

// File: rtl/rfs_scheduler_chk.sv
module rfs_scheduler_chk #(
    parameter int unsigned REF_CYCLES = 4,
    parameter int unsigned MAX_DEFER  = 6
) (
    input logic clk,
    input logic rst_n,
    input logic burst_active,
    input logic refresh_stb,
    input logic refresh_busy,
    input logic mem_grant,
    input logic pend,
    input logic hold
);

    int unsigned age_q;
    int unsigned run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 0;
            run_q <= 0;
        end else begin
            age_q <= pend ? age_q + 1 : 0;
            run_q <= refresh_busy ? run_q + 1 : 0;
        end
    end

    // R6
    strobe_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stb |-> refresh_busy);

    // R6
    strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stb |=> !refresh_stb);

    // R6
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= REF_CYCLES);

    // R4
    defer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        age_q <= MAX_DEFER);

    // R10
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_stb && !$past(refresh_stb) |-> $past(!burst_active));

    // R7
    held_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(refresh_busy) && $past(hold) |-> mem_grant);

endmodule

bind rfs_scheduler rfs_scheduler_chk #(
    .REF_CYCLES (REF_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_active (burst_active),
    .refresh_stb  (refresh_stb),
    .refresh_busy (refresh_busy),
    .mem_grant    (mem_grant),
    .pend         (pend_w),
    .hold         (hold_w)
);

// File: tb/rfs_scheduler_test.sv
module rfs_scheduler_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rate_val = 8'd0;
    logic       burst_active = 1'b0;
    logic       mem_req = 1'b0;
    logic       req_dram = 1'b0;
    logic       refresh_stb;
    logic       refresh_busy;
    logic       mem_grant;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    // behavioural reference state
    bit m_pend, m_hold, m_stb, m_gnt;
    int m_left;

    always #5 clk = ~clk;

    rfs_scheduler uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rate_val     (rate_val),
        .burst_active (burst_active),
        .mem_req      (mem_req),
        .req_dram     (req_dram),
        .refresh_stb  (refresh_stb),
        .refresh_busy (refresh_busy),
        .mem_grant    (mem_grant)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Reference: period counted from reset, refresh deferred behind bursts,
    // DRAM requests parked while a refresh occupies the array.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc = 0; m_pend = 0; m_hold = 0; m_stb = 0; m_gnt = 0; m_left = 0;
        end else begin
            int  period;
            bit  due, want_start, go, want, free;
            period     = 16 * (int'(rate_val) + 1);
            due        = ((cyc + 1) % period) == 0;
            want_start = m_pend || due;
            go         = want_start && !burst_active && (m_left == 0);
            want       = m_hold || (mem_req && req_dram);
            free       = (m_left <= 1) && !go;
            m_gnt      = (want && free) || (mem_req && !req_dram);
            m_hold     = want && !free;
            m_pend     = want_start && !go;
            m_stb      = go;
            if (go) m_left = 4;
            else if (m_left > 0) m_left = m_left - 1;
            cyc = cyc + 1;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2 strobe vs model", int'(refresh_stb), int'(m_stb));
            check("R6 busy vs model", int'(refresh_busy), int'(m_left != 0));
            check("R7 grant vs model", int'(mem_grant), int'(m_gnt));
        end
    end

    task automatic at(input int k);
        while (cyc < k) @(negedge clk);
    endtask

    task automatic do_reset(input logic [7:0] rate);
        @(negedge clk);
        rst_n = 1'b0;
        rate_val = rate;
        burst_active = 1'b0; mem_req = 1'b0; req_dram = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 strobe in reset", int'(refresh_stb), 0);
        check("R1 busy in reset", int'(refresh_busy), 0);
        check("R1 grant in reset", int'(mem_grant), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 strobe after reset", int'(refresh_stb), 0);
        check("R1 busy after reset", int'(refresh_busy), 0);
        check("R1 grant after reset", int'(mem_grant), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
        finish_up();
    end

    initial begin
        // Phase A: N = 0, period 16
        do_reset(8'd0);
        at(15); check("R2 no strobe before period", int'(refresh_stb), 0);
        at(16); check("R2 first strobe", int'(refresh_stb), 1);
                check("R6 busy with strobe", int'(refresh_busy), 1);
        // R7: DRAM request during refresh is held
        at(17); check("R6 strobe one cycle", int'(refresh_stb), 0);
                mem_req = 1'b1; req_dram = 1'b1;
        at(18); mem_req = 1'b0; req_dram = 1'b0;
                check("R7 held during busy", int'(mem_grant), 0);
        at(19); check("R6 busy fourth cycle", int'(refresh_busy), 1);
                check("R7 still held", int'(mem_grant), 0);
        at(20); check("R6 busy ends", int'(refresh_busy), 0);
                check("R7 grant when busy drops", int'(mem_grant), 1);
        // R9: other target not delayed
        at(33); mem_req = 1'b1; req_dram = 1'b0;
        at(34); mem_req = 1'b0;
                check("R9 busy while granting", int'(refresh_busy), 1);
                check("R9 immediate grant", int'(mem_grant), 1);
        // R8: DRAM request in the same cycle a refresh starts
        at(47); mem_req = 1'b1; req_dram = 1'b1;
        at(48); mem_req = 1'b0; req_dram = 1'b0;
                check("R8 refresh first", int'(refresh_stb), 1);
                check("R8 no grant yet", int'(mem_grant), 0);
        at(52); check("R8 grant after refresh", int'(mem_grant), 1);
        // R4/R10: burst covering the due time at state 63
        at(61); burst_active = 1'b1;
        at(64); check("R10 no strobe during burst", int'(refresh_stb), 0);
        at(67); burst_active = 1'b0;
                check("R4 still deferred", int'(refresh_stb), 0);
        at(68); check("R4 strobe after burst", int'(refresh_stb), 1);
        // R5: grid kept
        at(79); check("R5 no early strobe", int'(refresh_stb), 0);
        at(80); check("R5 next strobe on grid", int'(refresh_stb), 1);
        // R7: idle DRAM request granted next cycle
        at(85); mem_req = 1'b1; req_dram = 1'b1;
        at(86); mem_req = 1'b0; req_dram = 1'b0;
                check("R7 idle grant", int'(mem_grant), 1);
        at(87); check("R7 grant one cycle", int'(mem_grant), 0);
        at(120);

        // Phase B: N = 24, period 400
        do_reset(8'd24);
        at(399); check("R3 no strobe at 399", int'(refresh_stb), 0);
        at(400); check("R3 strobe at 400", int'(refresh_stb), 1);
        at(799); check("R3 no strobe at 799", int'(refresh_stb), 0);
        at(800); check("R3 strobe at 800", int'(refresh_stb), 1);

        // Phase C: N = 255, period 4096
        do_reset(8'd255);
        at(4095); check("R2 max rate not yet", int'(refresh_stb), 0);
        at(4096); check("R2 max rate strobe", int'(refresh_stb), 1);
        at(4100);

        finish_up();
    end

endmodule